// File: doc/BRIEF.md
# Indexed Configuration Window with Mode-Change Lock

This block gives a host a two-location window into a bank of up to sixteen byte-wide configuration registers. Location 0 is a control byte. It holds a four-bit pointer into the bank, a mode-change enable flag and a transfer-request disable flag. Location 1 reads and writes the bank entry that the pointer selects. For a set number of clocks after reset the block is in an initialization lockout. During the lockout it ignores every host write and returns a fixed pattern on both locations.

Two bank entries hold the sample format and the interface settings. The host can change them only while mode-change enable is set. The one exception is a small group of interface bits (the playback and capture enables), which can be changed at any time. When the host clears mode-change enable, a settle window of a fixed number of sample ticks starts. During this window a calibration-busy flag is high, both converter paths are muted and the capture data is replaced by its midscale code. A sample-tick input stands in for the converter clock. Mute and busy outputs stand in for the converter controls.

Top module: `cfgwin_port`

## Requirements
- R1: A read of location 0 returns {init, mce, trd, 0, ptr[3:0]}, with init in bit 7, mce in bit 6, trd in bit 5, bit 4 always 0 and the pointer in bits 3:0. The host's value for bit 4 is dropped.
- R2: For INIT_CYCLES clocks after reset, both locations read 8'h80, and writes to either location have no effect.
- R3: When the lockout ends, location 0 reads 8'h40, meaning mce is set and the pointer is 0.
- R4: While mce is 0, a write through location 1 to the format entry (pointer FMT_IDX, default 8) is dropped and the entry keeps its value. While mce is 1 the write is stored.
- R5: While mce is 0, a write to the interface entry (pointer IFC_IDX, default 9) changes only the bits in IFC_FREE_MASK (default 8'h03). All other bits keep their values.
- R6: Every other bank entry accepts writes whatever the state of mce.
- R7: While mce is 1, both bits of dac_mute are 1.
- R8: When mce is 0 and no settle window is running, dac_mute[0] equals bit 7 of entry LMUTE_IDX (default 6) and dac_mute[1] equals bit 7 of entry RMUTE_IDX (default 7).
- R9: A write that moves mce from 1 to 0 raises cal_busy in the next cycle. cal_busy stays high for exactly SETTLE_TICKS (default 128) sample ticks.
- R10: While cal_busy is high, adc_mute is 1, both dac_mute bits are 1 and capture_out carries midscale (16'h8000 in offset binary). At all other times adc_mute is 0 and capture_out equals capture_in.
- R11: A write that sets mce ends any running settle window, so cal_busy is 0 in the next cycle. The next exit from mce then starts a full window again.
- R12: The trd bit written to location 0 appears on trd_req from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | 0 = control/pointer, 1 = data window |
| host_wr | input | 1 | Write strobe for one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| sample_tick | input | 1 | One pulse per sample period |
| capture_in | input | SAMPLE_W | Raw capture sample |
| capture_out | output | SAMPLE_W | Capture sample, held at midscale while settling |
| dac_mute | output | 2 | Playback mute {right, left} |
| adc_mute | output | 1 | Capture mute, high while settling |
| cal_busy | output | 1 | Calibration/settle in progress |
| trd_req | output | 1 | Stored transfer-request disable flag |

## Verification
The format entry, the interface entry and an ordinary entry are each written once with mce set and again with it clear. This separates full locking, masked locking and no locking. Control writes with the reserved bit and the trd bit set show whether location 0 stores the right fields. The settle window is timed by counting ticks up to one short of the limit and then to the limit itself. A window that is cut short by setting mce and then restarted shows that the count is cleared rather than resumed. Writes made during the lockout are read back once it ends, to prove they were dropped.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
   localparam int BYTE_W   = 8;
   localparam int PTR_W    = 4;
   localparam int MAX_REGS = 1 << PTR_W;

   localparam logic [BYTE_W-1:0] LOCKOUT_READ = 8'h80;

   localparam int BIT_INIT = 7;
   localparam int BIT_MCE  = 6;
   localparam int BIT_TRD  = 5;
   localparam int BIT_RSV  = 4;

   typedef enum logic {
      LOC_CTRL = 1'b0,
      LOC_DATA = 1'b1
   } loc_e;
endpackage

// File: rtl/cfgwin_init_seq.sv
module cfgwin_init_seq #(
   parameter int INIT_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic init_active
);
   localparam int CNT_W = $clog2(INIT_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES);

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign init_active = (cnt_q != LAST);

   assert_init_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !init_active |=> !init_active);
endmodule

// File: rtl/cfgwin_bank.sv
module cfgwin_bank
   import cfgwin_pkg::*;
#(
   parameter int                NUM_REGS      = 16,
   parameter int                FMT_IDX       = 8,
   parameter int                IFC_IDX       = 9,
   parameter logic [BYTE_W-1:0] IFC_FREE_MASK = 8'h03
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [PTR_W-1:0]                 wr_ptr,
   input  logic [BYTE_W-1:0]                wr_data,
   input  logic                             mce,
   output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs
);
   if (NUM_REGS < 2 || NUM_REGS > MAX_REGS) begin : g_bad_depth
      $error("NUM_REGS out of range");
   end
   if (FMT_IDX >= NUM_REGS || IFC_IDX >= NUM_REGS || FMT_IDX == IFC_IDX) begin : g_bad_idx
      $error("locked entry indices invalid");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
      localparam logic [PTR_W-1:0] MY_PTR = PTR_W'(g);
      logic [BYTE_W-1:0] wmask;

      if (g == FMT_IDX) begin : g_fmt
         assign wmask = mce ? '1 : '0;
      end else if (g == IFC_IDX) begin : g_ifc
         assign wmask = mce ? '1 : IFC_FREE_MASK;
      end else begin : g_free
         assign wmask = '1;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (wr_en && wr_ptr == MY_PTR)
            regs[g] <= (regs[g] & ~wmask) | (wr_data & wmask);
      end
   end

   assert_fmt_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ptr == PTR_W'(FMT_IDX) && !mce) |=> $stable(regs[FMT_IDX]));

   assert_ifc_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ptr == PTR_W'(IFC_IDX) && !mce)
      |=> ((regs[IFC_IDX] & ~IFC_FREE_MASK) == ($past(regs[IFC_IDX]) & ~IFC_FREE_MASK)));
endmodule

// File: rtl/cfgwin_settle.sv
module cfgwin_settle #(
   parameter int SETTLE_TICKS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic tick,
   output logic busy
);
   localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(SETTLE_TICKS);

   if (SETTLE_TICKS < 1) begin : g_bad_settle
      $error("SETTLE_TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (start)              cnt_q <= FULL;
      else if (abort)              cnt_q <= '0;
      else if (tick && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   assert_window_loaded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == FULL));
   assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
   assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !start) |=> !busy);
endmodule

// File: rtl/cfgwin_port.sv
module cfgwin_port
   import cfgwin_pkg::*;
#(
   parameter int                NUM_REGS       = 16,
   parameter int                FMT_IDX        = 8,
   parameter int                IFC_IDX        = 9,
   parameter int                LMUTE_IDX      = 6,
   parameter int                RMUTE_IDX      = 7,
   parameter logic [7:0]        IFC_FREE_MASK  = 8'h03,
   parameter int                INIT_CYCLES    = 16,
   parameter int                SETTLE_TICKS   = 128,
   parameter int                SAMPLE_W       = 16,
   parameter bit                SIGNED_SAMPLES = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_addr,
   input  logic                host_wr,
   input  logic [7:0]          host_wdata,
   output logic [7:0]          host_rdata,
   input  logic                sample_tick,
   input  logic [SAMPLE_W-1:0] capture_in,
   output logic [SAMPLE_W-1:0] capture_out,
   output logic [1:0]          dac_mute,
   output logic                adc_mute,
   output logic                cal_busy,
   output logic                trd_req
);
   localparam int MUTE_BIT = BYTE_W - 1;

   if (LMUTE_IDX >= NUM_REGS || RMUTE_IDX >= NUM_REGS) begin : g_bad_mute
      $error("mute entry index out of range");
   end
   if (SAMPLE_W < 2) begin : g_bad_width
      $error("SAMPLE_W must be at least 2");
   end

   logic                             init_active;
   logic                             mce_q, trd_q;
   logic [PTR_W-1:0]                 ptr_q;
   logic [NUM_REGS-1:0][BYTE_W-1:0]  regs;
   logic                             ctrl_wr, data_wr;
   logic                             mce_exit, mce_entry;
   logic [BYTE_W-1:0]                sel_entry;
   logic [SAMPLE_W-1:0]              midscale;

   cfgwin_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
      .clk(clk), .rst_n(rst_n), .init_active(init_active)
   );

   assign ctrl_wr = host_wr && !init_active && (loc_e'(host_addr) == LOC_CTRL);
   assign data_wr = host_wr && !init_active && (loc_e'(host_addr) == LOC_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mce_q <= 1'b1;
         trd_q <= 1'b0;
         ptr_q <= '0;
      end else if (ctrl_wr) begin
         mce_q <= host_wdata[BIT_MCE];
         trd_q <= host_wdata[BIT_TRD];
         ptr_q <= host_wdata[PTR_W-1:0];
      end
   end

   assign mce_exit  = ctrl_wr &&  mce_q && !host_wdata[BIT_MCE];
   assign mce_entry = ctrl_wr && !mce_q &&  host_wdata[BIT_MCE];

   cfgwin_bank #(
      .NUM_REGS(NUM_REGS), .FMT_IDX(FMT_IDX), .IFC_IDX(IFC_IDX),
      .IFC_FREE_MASK(IFC_FREE_MASK)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_ptr(ptr_q),
      .wr_data(host_wdata), .mce(mce_q), .regs(regs)
   );

   cfgwin_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
      .clk(clk), .rst_n(rst_n), .start(mce_exit),
      .abort(mce_q || mce_entry), .tick(sample_tick), .busy(cal_busy)
   );

   always_comb begin
      sel_entry = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (ptr_q == PTR_W'(i)) sel_entry = regs[i];
   end

   always_comb begin
      if (init_active)
         host_rdata = LOCKOUT_READ;
      else if (loc_e'(host_addr) == LOC_CTRL) begin
         host_rdata          = '0;
         host_rdata[BIT_MCE] = mce_q;
         host_rdata[BIT_TRD] = trd_q;
         host_rdata[PTR_W-1:0] = ptr_q;
      end else
         host_rdata = sel_entry;
   end

   if (SIGNED_SAMPLES) begin : g_mid_signed
      assign midscale = '0;
   end else begin : g_mid_offset
      assign midscale = {1'b1, {(SAMPLE_W-1){1'b0}}};
   end

   assign capture_out = cal_busy ? midscale : capture_in;
   assign adc_mute    = cal_busy;
   assign dac_mute[0] = mce_q || cal_busy || regs[LMUTE_IDX][MUTE_BIT];
   assign dac_mute[1] = mce_q || cal_busy || regs[RMUTE_IDX][MUTE_BIT];
   assign trd_req     = trd_q;

   assert_lockout_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      init_active |-> (host_rdata == LOCKOUT_READ));
   assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_active && loc_e'(host_addr) == LOC_CTRL) |-> !host_rdata[BIT_RSV]);
   assert_mce_mutes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mce_q |-> (dac_mute == 2'b11));
   assert_exit_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mce_q) |-> cal_busy);
   assert_settle_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |-> (capture_out == midscale && adc_mute && dac_mute == 2'b11));
   assert_mce_no_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mce_q |-> !cal_busy);
endmodule

// File: tb/cfgwin_port_bench.sv
module cfgwin_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_addr = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        sample_tick = 1'b0;
   logic [15:0] capture_in = 16'h1234;
   logic [15:0] capture_out;
   logic [1:0]  dac_mute;
   logic        adc_mute, cal_busy, trd_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   cfgwin_port u_cfgwin_port (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .sample_tick(sample_tick), .capture_in(capture_in),
      .capture_out(capture_out), .dac_mute(dac_mute), .adc_mute(adc_mute),
      .cal_busy(cal_busy), .trd_req(trd_req)
   );

   // {write, addr, data, expected read}
   localparam int NV = 20;
   localparam logic [17:0] VEC [NV] = '{
      {1'b1, 1'b0, 8'h48, 8'h00},  // pointer 8
      {1'b1, 1'b1, 8'hA5, 8'h00},
      {1'b0, 1'b1, 8'h00, 8'hA5},  // R4 format writable under mce
      {1'b1, 1'b0, 8'h49, 8'h00},
      {1'b1, 1'b1, 8'h5C, 8'h00},
      {1'b0, 1'b1, 8'h00, 8'h5C},  // R5 interface writable under mce
      {1'b1, 1'b0, 8'h46, 8'h00},
      {1'b1, 1'b1, 8'h80, 8'h00},
      {1'b0, 1'b1, 8'h00, 8'h80},  // R6 left mute entry
      {1'b1, 1'b0, 8'h47, 8'h00},
      {1'b1, 1'b1, 8'h00, 8'h00},
      {1'b0, 1'b1, 8'h00, 8'h00},  // R6 right mute entry
      {1'b1, 1'b0, 8'h5A, 8'h00},
      {1'b0, 1'b0, 8'h00, 8'h4A},  // R1 reserved bit dropped
      {1'b1, 1'b0, 8'h62, 8'h00},
      {1'b0, 1'b0, 8'h00, 8'h62},  // R12 trd stored
      {1'b1, 1'b0, 8'h42, 8'h00},
      {1'b1, 1'b1, 8'h3C, 8'h00},
      {1'b0, 1'b1, 8'h00, 8'h3C},  // R6 plain entry
      {1'b0, 1'b0, 8'h00, 8'h42}   // R1 control readback
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic a, input logic [7:0] exp, input string req);
      @(negedge clk);
      host_addr = a;
      #1;
      check(host_rdata == exp, req, host_rdata, exp);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sample_tick = 1'b1;
         @(negedge clk); sample_tick = 1'b0;
      end
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // lockout behaviour
      rd(1'b0, 8'h80, "R2 ctrl lockout");
      rd(1'b1, 8'h80, "R2 data lockout");
      wr(1'b1, 8'hEE);
      wr(1'b0, 8'h05);
      repeat (20) @(negedge clk);
      rd(1'b0, 8'h40, "R3 after lockout");
      rd(1'b1, 8'h00, "R2 write dropped");
      check(dac_mute == 2'b11, "R7 mute under mce", dac_mute, 2'b11);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v][17]) wr(VEC[v][16], VEC[v][15:8]);
         else            rd(VEC[v][16], VEC[v][7:0], "R1/R4/R5/R6/R12 vector");
      end

      wr(1'b0, 8'h62);
      check(trd_req == 1'b1, "R12 trd set", trd_req, 1);
      wr(1'b0, 8'h42);
      check(trd_req == 1'b0, "R12 trd clear", trd_req, 0);

      // leave mode change
      wr(1'b0, 8'h08);
      #1;
      check(cal_busy == 1'b1, "R9 busy on exit", cal_busy, 1);
      check(adc_mute == 1'b1, "R10 adc muted", adc_mute, 1);
      check(capture_out == 16'h8000, "R10 midscale", capture_out, 16'h8000);
      check(dac_mute == 2'b11, "R10 dac muted", dac_mute, 2'b11);
      rd(1'b0, 8'h08, "R1 mce cleared");
      wr(1'b1, 8'h11);
      rd(1'b1, 8'hA5, "R4 format locked");
      wr(1'b0, 8'h09);
      wr(1'b1, 8'hFF);
      rd(1'b1, 8'h5F, "R5 interface masked");
      wr(1'b0, 8'h02);
      wr(1'b1, 8'h77);
      rd(1'b1, 8'h77, "R6 free entry");

      ticks(127);
      #1;
      check(cal_busy == 1'b1, "R9 busy at 127", cal_busy, 1);
      ticks(1);
      #1;
      check(cal_busy == 1'b0, "R9 done at 128", cal_busy, 0);
      check(dac_mute == 2'b01, "R8 mute follows bits", dac_mute, 2'b01);
      check(adc_mute == 1'b0, "R10 adc unmuted", adc_mute, 0);
      check(capture_out == 16'h1234, "R10 pass through", capture_out, 16'h1234);
      wr(1'b0, 8'h07);
      wr(1'b1, 8'h80);
      #1;
      check(dac_mute == 2'b11, "R8 right mute set", dac_mute, 2'b11);
      wr(1'b1, 8'h00);
      #1;
      check(dac_mute == 2'b01, "R8 right mute clear", dac_mute, 2'b01);

      // abort and restart
      wr(1'b0, 8'h48);
      check(dac_mute == 2'b11, "R7 re-entry mutes", dac_mute, 2'b11);
      wr(1'b0, 8'h08);
      ticks(10);
      wr(1'b0, 8'h48);
      #1;
      check(cal_busy == 1'b0, "R11 abort", cal_busy, 0);
      wr(1'b0, 8'h08);
      ticks(127);
      #1;
      check(cal_busy == 1'b1, "R11 full window again", cal_busy, 1);
      ticks(1);
      #1;
      check(cal_busy == 1'b0, "R11 restarted window ends", cal_busy, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule